// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers interrupt requests from a parameterized set of external source lines and offers the most urgent one that may be delivered to a single processor through one request output. Software configures each source through a simple register bus. The configuration covers the source's vector, priority, sense and polarity, a mask, and whether the source is routed to this processor. The processor side provides a task-priority threshold, an acknowledge register and an end-of-interrupt register.

Servicing works as follows. The processor reads the acknowledge register and receives the vector of the winning source. That priority level is then recorded as in service, so only strictly more urgent sources can interrupt it. A write to the end-of-interrupt register retires the most urgent in-service level. When nothing is deliverable, an acknowledge returns a programmable spurious vector. A soft-reset bit reinitializes the block. A read-only feature register describes the block's size.

The bus uses one-cycle read and write strobes. Read data appears on `bus_rdata_o` after the clock edge that samples the read strobe, and stays there until the next read.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A source whose mask bit (bit 31 of its configuration word at address 0x40+2*i) is set is never delivered, even when its input is active.
- R2: Bit 23 of the configuration word selects the sense: 1 means level, 0 means edge. Bit 22 selects the polarity: 1 means active-high or rising, 0 means active-low or falling. A level source is pending exactly while its input is at the active level. An edge source latches a qualifying edge, and an acknowledge of that source clears the latch.
- R3: An edge that arrives while its source's priority level is in service stays latched. It is presented again once end-of-interrupt retires that level.
- R4: A read of address 0x04 returns the vector (bits 7:0 of the configuration word) of the deliverable source with the highest priority (bits 19:16). Ties go to the lower source number. The read marks that priority level as in service.
- R5: A write to address 0x05 clears the highest in-service level. Lower in-service levels stay recorded and keep blocking sources at or below them.
- R6: A read of address 0x04 with no deliverable source returns the spurious vector. The spurious vector is held in bits 7:0 at address 0x02 and resets to 0xFF.
- R7: A source is deliverable only if its priority is strictly greater than the task priority (bits 3:0 at address 0x03). Task priority 15 blocks every source, and task priority 0 admits any enabled source of priority 1 or more.
- R8: Writing 1 to bit 0 at address 0x00 starts a soft reset. Bit 0 reads as 1 for RST_CYC cycles and then clears. After the soft reset, every register has its reset value.
- R9: The feature register at address 0x01 reads NSRC-1 in bits 7:0, NCPU-1 in bits 15:8 and VERSION (1 to 3) in bits 27:24.
- R10: A source is delivered only when bit CPU_ID of its destination word (address 0x41+2*i) is set.
- R11: After reset, every source is masked, every destination bit is clear, no level is in service, and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | 8 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid after the edge that samples the read strobe |
| src_in_i | input | NSRC | Raw source lines |
| irq_o | output | 1 | Request to the processor: a deliverable source exists |

## Verification
A corrupted in-service set shows within one cycle at `irq_o`. A stale bit keeps a source blocked after end-of-interrupt, and a lost bit lets an equal-priority source through at once. A wrong edge latch shows as a request that fails to rise after a pulse or fails to fall after its acknowledge. Arbitration or mask faults appear in the next acknowledge value. The bench compares that value on every read against a model of priority, tie order, mask, routing and threshold.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int PRIO_W = 4;
    localparam int NLVL   = 1 << PRIO_W;
    localparam int VEC_W  = 8;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] A_GCFG     = 8'h00;
    localparam logic [ADDR_W-1:0] A_FEAT     = 8'h01;
    localparam logic [ADDR_W-1:0] A_SPUR     = 8'h02;
    localparam logic [ADDR_W-1:0] A_TPR      = 8'h03;
    localparam logic [ADDR_W-1:0] A_ACK      = 8'h04;
    localparam logic [ADDR_W-1:0] A_EOI      = 8'h05;
    localparam logic [ADDR_W-1:0] A_SRC_BASE = 8'h40;

    localparam int B_MASK  = 31;
    localparam int B_LEVEL = 23;
    localparam int B_POL   = 22;
    localparam int B_PRIO  = 16;

    typedef struct packed {
        logic              mask;
        logic              level;
        logic              pol;
        logic [PRIO_W-1:0] prio;
        logic [VEC_W-1:0]  vec;
    } src_cfg_t;

    localparam src_cfg_t CFG_RST = '{mask: 1'b1, level: 1'b0, pol: 1'b0,
                                     prio: '0, vec: '0};

    function automatic logic [DATA_W-1:0] cfg_to_word(src_cfg_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[B_MASK]              = c.mask;
        w[B_LEVEL]             = c.level;
        w[B_POL]               = c.pol;
        w[B_PRIO +: PRIO_W]    = c.prio;
        w[VEC_W-1:0]           = c.vec;
        return w;
    endfunction

    function automatic src_cfg_t word_to_cfg(logic [DATA_W-1:0] w);
        src_cfg_t c;
        c.mask  = w[B_MASK];
        c.level = w[B_LEVEL];
        c.pol   = w[B_POL];
        c.prio  = w[B_PRIO +: PRIO_W];
        c.vec   = w[VEC_W-1:0];
        return c;
    endfunction
endpackage

// File: rtl/pic_src_cell.sv
module pic_src_cell (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    input  logic raw_i,
    input  logic level_i,
    input  logic pol_pos_i,
    input  logic ack_clr_i,
    output logic pending_o
);
    typedef struct packed {
        logic prev;
        logic latch;
    } cell_t;

    cell_t cell_d, cell_q;
    logic  edge_hit;
    logic  lvl_active;

    always_comb begin
        lvl_active = (raw_i == pol_pos_i);
        edge_hit   = pol_pos_i ? (raw_i && !cell_q.prev) : (!raw_i && cell_q.prev);
        cell_d.prev = raw_i;
        if (clr_i || level_i) begin
            cell_d.latch = 1'b0;
        end else begin
            cell_d.latch = (cell_q.latch && !ack_clr_i) || edge_hit;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cell_q <= '0;
        else         cell_q <= cell_d;
    end

    assign pending_o = level_i ? lvl_active : cell_q.latch;

    // R2: a rising edge on a positive edge source is captured
    p_edge_capture_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clr_i && !level_i && pol_pos_i && raw_i && !$past(raw_i)) |=> cell_q.latch);
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter import pic_pkg::*; #(
    parameter int NSRC  = 8,
    parameter int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [NSRC-1:0]             pend_i,
    input  logic [NSRC-1:0]             mask_i,
    input  logic [NSRC-1:0]             route_i,
    input  logic [NSRC-1:0][PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0]           thr_i,
    output logic                        found_o,
    output logic [IDX_W-1:0]            win_idx_o,
    output logic [PRIO_W-1:0]           win_prio_o
);
    always_comb begin
        found_o    = 1'b0;
        win_idx_o  = '0;
        win_prio_o = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (pend_i[i] && !mask_i[i] && route_i[i] && (prio_i[i] > thr_i)
                && (!found_o || (prio_i[i] > win_prio_o))) begin
                found_o    = 1'b1;
                win_idx_o  = IDX_W'(i);
                win_prio_o = prio_i[i];
            end
        end
    end

    always_comb begin
        if (found_o) begin
            p_win_above_thr_r7: assert (win_prio_o > thr_i);
            p_win_unmasked_r1:  assert (!mask_i[win_idx_o]);
            p_win_routed_r10:   assert (route_i[win_idx_o]);
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl import pic_pkg::*; #(
    parameter int NSRC    = 8,
    parameter int NCPU    = 4,
    parameter int CPU_ID  = 0,
    parameter int VERSION = 2,
    parameter int RST_CYC = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic [NSRC-1:0]   src_in_i,
    output logic              irq_o
);
    localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;
    localparam int CNT_W = $clog2(RST_CYC + 1);
    localparam logic [DATA_W-1:0] FEAT_WORD =
        {4'd0, 4'(VERSION), 8'd0, 8'(NCPU - 1), 8'(NSRC - 1)};

    typedef struct packed {
        src_cfg_t [NSRC-1:0] cfg;
        logic [NSRC-1:0]     dest;
        logic [VEC_W-1:0]    spur;
        logic [PRIO_W-1:0]   tpr;
        logic [NLVL-1:0]     isr;
        logic [CNT_W-1:0]    rcnt;
        logic [DATA_W-1:0]   rdata;
    } state_t;

    function automatic state_t rst_state();
        state_t s;
        for (int i = 0; i < NSRC; i++) s.cfg[i] = CFG_RST;
        s.dest  = '0;
        s.spur  = '1;
        s.tpr   = '0;
        s.isr   = '0;
        s.rcnt  = '0;
        s.rdata = '0;
        return s;
    endfunction

    state_t state_d, state_q;

    logic [NSRC-1:0]             pend, mask_v, route_v, ack_clr;
    logic [NSRC-1:0][PRIO_W-1:0] prio_v;
    logic                        found, busy, ack_fire;
    logic [IDX_W-1:0]            win_idx;
    logic [PRIO_W-1:0]           win_prio, isr_top, thr;
    logic [DATA_W-1:0]           rd_word;
    logic                        unused_wbits;

    assign unused_wbits = ^bus_wdata_i;
    assign busy = (state_q.rcnt != '0);

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        pic_src_cell u_cell (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .clr_i     (busy),
            .raw_i     (src_in_i[g]),
            .level_i   (state_q.cfg[g].level),
            .pol_pos_i (state_q.cfg[g].pol),
            .ack_clr_i (ack_clr[g]),
            .pending_o (pend[g])
        );
        assign mask_v[g]  = state_q.cfg[g].mask;
        assign route_v[g] = state_q.dest[g];
        assign prio_v[g]  = state_q.cfg[g].prio;
        assign ack_clr[g] = ack_fire && (win_idx == IDX_W'(g));
    end

    always_comb begin
        isr_top = '0;
        for (int l = 0; l < NLVL; l++) begin
            if (state_q.isr[l]) isr_top = PRIO_W'(l);
        end
        thr = (state_q.tpr > isr_top) ? state_q.tpr : isr_top;
    end

    pic_arbiter #(.NSRC(NSRC), .IDX_W(IDX_W)) u_arb (
        .pend_i     (pend),
        .mask_i     (mask_v),
        .route_i    (route_v),
        .prio_i     (prio_v),
        .thr_i      (thr),
        .found_o    (found),
        .win_idx_o  (win_idx),
        .win_prio_o (win_prio)
    );

    assign ack_fire = bus_rd_i && (bus_addr_i == A_ACK) && found && !busy;

    always_comb begin
        case (bus_addr_i)
            A_GCFG:  rd_word = DATA_W'(busy);
            A_FEAT:  rd_word = FEAT_WORD;
            A_SPUR:  rd_word = DATA_W'(state_q.spur);
            A_TPR:   rd_word = DATA_W'(state_q.tpr);
            A_ACK:   rd_word = found ? DATA_W'(state_q.cfg[win_idx].vec)
                                     : DATA_W'(state_q.spur);
            default: begin
                rd_word = '0;
                for (int i = 0; i < NSRC; i++) begin
                    if (bus_addr_i == A_SRC_BASE + ADDR_W'(2 * i))
                        rd_word = cfg_to_word(state_q.cfg[i]);
                    if (bus_addr_i == A_SRC_BASE + ADDR_W'(2 * i + 1))
                        rd_word = DATA_W'(state_q.dest[i]) << CPU_ID;
                end
            end
        endcase
    end

    always_comb begin
        state_d = state_q;
        if (busy) begin
            state_d      = rst_state();
            state_d.rcnt = state_q.rcnt - 1'b1;
        end else begin
            if (bus_wr_i) begin
                case (bus_addr_i)
                    A_GCFG: if (bus_wdata_i[0]) state_d.rcnt = CNT_W'(RST_CYC);
                    A_SPUR: state_d.spur = bus_wdata_i[VEC_W-1:0];
                    A_TPR:  state_d.tpr  = bus_wdata_i[PRIO_W-1:0];
                    A_EOI:  if (state_q.isr != '0) state_d.isr[isr_top] = 1'b0;
                    default: begin
                        for (int i = 0; i < NSRC; i++) begin
                            if (bus_addr_i == A_SRC_BASE + ADDR_W'(2 * i))
                                state_d.cfg[i] = word_to_cfg(bus_wdata_i);
                            if (bus_addr_i == A_SRC_BASE + ADDR_W'(2 * i + 1))
                                state_d.dest[i] = bus_wdata_i[CPU_ID];
                        end
                    end
                endcase
            end
            if (ack_fire) state_d.isr[win_prio] = 1'b1;
        end
        if (bus_rd_i) state_d.rdata = rd_word;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= rst_state();
        else         state_q <= state_d;
    end

    assign bus_rdata_o = state_q.rdata;
    assign irq_o       = found;

    // R4: an acknowledge records the winner's level as in service
    p_ack_marks_isr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_fire |=> state_q.isr[$past(win_prio)]);

    // R5: end-of-interrupt retires exactly one in-service level
    p_eoi_retires_one_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_wr_i && (bus_addr_i == A_EOI) && !busy && (state_q.isr != '0))
        |=> ($countones(state_q.isr) == $countones($past(state_q.isr)) - 1));

    // R6: empty acknowledge returns the spurious vector
    p_spurious_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_rd_i && (bus_addr_i == A_ACK) && !found && !busy)
        |=> (bus_rdata_o == DATA_W'($past(state_q.spur))));

    // R7: task priority 15 blocks everything
    p_tpr_max_blocks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q.tpr == '1) |-> !irq_o);

    // R8: the soft reset counter always runs down
    p_rst_counts_down_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy |=> (state_q.rcnt < $past(state_q.rcnt)));

    // R8: once soft reset completes every source is masked and idle
    p_rst_masks_all_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy) |-> ((&mask_v) && (state_q.isr == '0) && !irq_o));
endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
    import pic_pkg::*;
    localparam int NSRC    = 8;
    localparam int RST_CYC = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0, bus_rd = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic [NSRC-1:0]   src_in = '0;
    logic              irq;

    int checks = 0;
    int fails  = 0;

    logic [3:0] r_prio [NSRC];
    logic       r_mask [NSRC];
    logic       r_in   [NSRC];

    always #4 clk = ~clk;

    prio_irq_ctrl #(.NSRC(NSRC), .NCPU(4), .CPU_ID(0), .VERSION(2), .RST_CYC(RST_CYC))
    i_prio_irq_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
        .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .src_in_i(src_in), .irq_o(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] mk(input logic m, input logic lv, input logic pol,
                                       input logic [3:0] pr, input logic [7:0] v);
        return {m, 7'd0, lv, pol, 2'd0, pr, 8'd0, v};
    endfunction

    task automatic cfg(input int i, input logic m, input logic lv, input logic pol,
                       input logic [3:0] pr, input logic [7:0] v);
        wr(8'h40 + 8'(2 * i), mk(m, lv, pol, pr, v));
    endtask

    task automatic pulse(input int i);
        @(negedge clk); src_in[i] = 1'b1;
        @(negedge clk); src_in[i] = 1'b0;
    endtask

    function automatic logic [31:0] model_ack();
        logic       hit = 1'b0;
        logic [3:0] best = '0;
        logic [7:0] v = 8'hA5;
        for (int i = 0; i < NSRC; i++) begin
            if (!r_mask[i] && r_in[i] && r_prio[i] != 4'd0 && (!hit || r_prio[i] > best)) begin
                hit = 1'b1; best = r_prio[i]; v = 8'h80 + 8'(i);
            end
        end
        return {24'd0, v};
    endfunction

    initial begin
        repeat (60000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd5150));
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R11 reset state
        check("R11 irq low after reset", 32'(irq), 32'd0);
        rd(8'h40, d); check("R11 source 0 masked", d, 32'h8000_0000);
        rd(A_ACK, d); check("R6 reset spurious value", d, 32'h0000_00FF);
        rd(A_FEAT, d); check("R9 feature word", d, 32'h0200_0307);

        wr(A_SPUR, 32'hA5);
        for (int i = 0; i < NSRC; i++) wr(8'h41 + 8'(2 * i), 32'd1);

        // R2 edge capture, R4 acknowledge
        cfg(3, 1'b0, 1'b0, 1'b1, 4'd5, 8'h33);
        pulse(3); idle(1);
        check("R2 edge latched", 32'(irq), 32'd1);
        rd(A_ACK, d); check("R4 ack vector edge source", d, 32'h33);
        check("R2 latch cleared by ack", 32'(irq), 32'd0);
        wr(A_EOI, 0); idle(1);
        check("R2 no request after eoi", 32'(irq), 32'd0);

        // R3 edge during service
        pulse(3); rd(A_ACK, d);
        pulse(3); idle(1);
        check("R3 held while in service", 32'(irq), 32'd0);
        wr(A_EOI, 0); idle(1);
        check("R3 re-presented after eoi", 32'(irq), 32'd1);
        rd(A_ACK, d); check("R3 second ack vector", d, 32'h33);
        wr(A_EOI, 0);
        cfg(3, 1'b1, 1'b0, 1'b1, 4'd5, 8'h33);

        // R1 mask
        cfg(4, 1'b1, 1'b1, 1'b1, 4'd7, 8'h44);
        src_in[4] = 1'b1; idle(2);
        check("R1 masked source silent", 32'(irq), 32'd0);
        rd(A_ACK, d); check("R6 programmed spurious", d, 32'hA5);
        src_in[4] = 1'b0;

        // R2 level, both polarities
        cfg(1, 1'b0, 1'b1, 1'b1, 4'd6, 8'h11);
        src_in[1] = 1'b1; idle(1);
        check("R2 level high active", 32'(irq), 32'd1);
        src_in[1] = 1'b0; idle(1);
        check("R2 level follows low", 32'(irq), 32'd0);
        cfg(1, 1'b0, 1'b1, 1'b0, 4'd6, 8'h11); idle(1);
        check("R2 active-low level asserted", 32'(irq), 32'd1);
        src_in[1] = 1'b1; idle(1);
        check("R2 active-low level released", 32'(irq), 32'd0);
        src_in[1] = 1'b0;
        cfg(1, 1'b1, 1'b1, 1'b0, 4'd6, 8'h11);

        // R10 routing, R7 threshold
        cfg(6, 1'b0, 1'b1, 1'b1, 4'd3, 8'h66);
        src_in[6] = 1'b1; idle(1);
        check("R10 routed source requests", 32'(irq), 32'd1);
        wr(8'h4D, 32'd0); idle(1);
        check("R10 unrouted source silent", 32'(irq), 32'd0);
        wr(8'h4D, 32'd1);
        wr(A_TPR, 32'd15); idle(1);
        check("R7 tpr 15 blocks", 32'(irq), 32'd0);
        wr(A_TPR, 32'd3); idle(1);
        check("R7 equal priority blocked", 32'(irq), 32'd0);
        wr(A_TPR, 32'd2); idle(1);
        check("R7 priority above tpr passes", 32'(irq), 32'd1);
        wr(A_TPR, 32'd0); idle(1);
        check("R7 tpr 0 passes", 32'(irq), 32'd1);
        src_in[6] = 1'b0;
        cfg(6, 1'b1, 1'b1, 1'b1, 4'd3, 8'h66);

        // R4 tie to lower index
        cfg(2, 1'b0, 1'b1, 1'b1, 4'd4, 8'h22);
        cfg(5, 1'b0, 1'b1, 1'b1, 4'd4, 8'h55);
        src_in[2] = 1'b1; src_in[5] = 1'b1;
        rd(A_ACK, d); check("R4 tie goes to lower index", d, 32'h22);
        wr(A_EOI, 0);

        // R5 nesting
        src_in[5] = 1'b0;
        cfg(5, 1'b0, 1'b1, 1'b1, 4'd9, 8'h55);
        rd(A_ACK, d); check("R4 single level ack", d, 32'h22);
        src_in[5] = 1'b1; idle(1);
        check("R5 higher priority preempts", 32'(irq), 32'd1);
        rd(A_ACK, d); check("R5 nested ack vector", d, 32'h55);
        check("R5 both levels block", 32'(irq), 32'd0);
        src_in[5] = 1'b0;
        wr(A_EOI, 0); idle(1);
        check("R5 lower level still in service", 32'(irq), 32'd0);
        wr(A_EOI, 0); idle(1);
        check("R5 all retired", 32'(irq), 32'd1);
        rd(A_ACK, d); check("R5 outer source again", d, 32'h22);
        wr(A_EOI, 0);
        src_in[2] = 1'b0;
        cfg(2, 1'b1, 1'b1, 1'b1, 4'd4, 8'h22);
        cfg(5, 1'b1, 1'b1, 1'b1, 4'd9, 8'h55);

        // random level mixes against model: R1 R4 R6 R7
        for (int it = 0; it < 40; it++) begin
            for (int i = 0; i < NSRC; i++) begin
                r_prio[i] = 4'($urandom_range(0, 15));
                r_mask[i] = ($urandom_range(0, 3) == 0);
                r_in[i]   = 1'($urandom_range(0, 1));
                cfg(i, r_mask[i], 1'b1, 1'b1, r_prio[i], 8'h80 + 8'(i));
                src_in[i] = r_in[i];
            end
            idle(1);
            check("R7 random request level", 32'(irq), 32'(model_ack() != 32'hA5));
            rd(A_ACK, d); check("R4 random ack vector", d, model_ack());
            wr(A_EOI, 0);
        end
        src_in = '0;

        // R8 soft reset
        wr(A_GCFG, 32'd1);
        rd(A_GCFG, d); check("R8 reset bit reads 1", d, 32'd1);
        idle(RST_CYC + 2);
        rd(A_GCFG, d); check("R8 reset bit self-clears", d, 32'd0);
        rd(8'h40, d); check("R8 source masked after soft reset", d, 32'h8000_0000);
        rd(A_SPUR, d); check("R8 spurious restored", d, 32'hFF);
        check("R8 irq low after soft reset", 32'(irq), 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule